// File: doc/BRIEF.md
# Cascadable LCD Column Data Loader

This block is the digital core of a column (segment) driver for a passive LCD panel. Display data for one line arrives as a stream of parallel words, four or eight bits wide, each taken on a falling edge of a shift clock. The words fill a data latch of `NOUT` bits in a scan direction the host chooses. A falling edge of the line pulse copies the data latch into a line latch. Each line latch bit is then combined with a frame inversion input and an active-low blanking input, which gives a 2-bit drive level code per column. The analog stage turns these codes into voltages.

Several of these blocks can be chained to drive a wide panel. Each block has two enable-link ports, and the scan direction decides which one listens and which one talks. A block only accepts data while its incoming enable is low. Once its own latch is full, it pulls its outgoing enable low so the next block in the chain starts taking words. The whole block runs on a fast system clock. The shift clock and the line pulse are sampled as ordinary inputs, and their falling edges are detected.

There are two state machines. The fill machine has the states FILL_READY and FILL_FULL. It goes from READY to FULL when the last word of a line is accepted, and from FULL back to READY on a line-pulse falling edge. The display machine has the states DISP_BLANK, DISP_NONSEL and DISP_SHOW. Blanking moves it from any state to BLANK. Releasing the blank moves it from BLANK to NONSEL. A line-pulse falling edge moves it from NONSEL to SHOW.

Top module: `seg_col_loader`

## Requirements
- R1: A word is taken from `data_in` only in a system-clock cycle where a falling edge of `shift_clk` is seen, the active enable input is low (0), and the current line is not yet full. Words presented while the enable input is high leave the data latch unchanged.
- R2: When `nibble_mode` is 1, each word is 4 bits taken from `data_in[3:0]`, and `data_in[7:4]` is ignored. When `nibble_mode` is 0, each word is all 8 bits of `data_in`.
- R3: Positions are numbered 0 to NOUT-1. Position p drives `drive_code[2p+1:2p]`. Let W be the word width. Word k (counted from 0 since the last line pulse) carries bit j at fill index k*W+j. When `dir_fwd` is 1, fill index i is position i. When `dir_fwd` is 0, fill index i is position NOUT-1-i.
- R4: A line is full after NOUT/W accepted words. From then on, the outgoing enable is low, and further words are ignored until the next line-pulse falling edge.
- R5: A falling edge of `line_pulse` copies the data latch into the line latch, returns the fill pointer to fill index 0, and sets the outgoing enable back high.
- R6: In SHOW state, a line latch bit of 1 gives code 2'b11 when `frame_inv` is 1 and code 2'b00 when it is 0. A line latch bit of 0 gives code 2'b10 when `frame_inv` is 1 and code 2'b01 when it is 0.
- R7: While `blank_n` is 0, every code is 2'b00 and the line latch is held cleared. Words keep loading into the data latch during this time.
- R8: After `blank_n` returns to 1, every code is the non-select level until the next line-pulse falling edge. The non-select level is 2'b10 when `frame_inv` is 1 and 2'b01 when it is 0. After that edge, the line latch contents are shown.
- R9: When `dir_fwd` is 1, link A is the enable input and link B drives the enable output (`link_b_oe`=1, `link_a_oe`=0). When `dir_fwd` is 0, the roles swap. A link that is not driving outputs 1.
- R10: When falling edges of `line_pulse` and `shift_clk` fall in the same cycle, the line transfer happens and the word is dropped. The next line then still needs NOUT/W further words.
- R11: After reset, every code is the non-select level, both link outputs are 1, and the data and line latches are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk | input | 1 | Data shift clock; falling edge takes a word |
| line_pulse | input | 1 | Line pulse; falling edge transfers the line |
| data_in | input | 8 | Parallel display data |
| nibble_mode | input | 1 | 1 = 4-bit words, 0 = 8-bit words |
| dir_fwd | input | 1 | 1 = fill from position 0 upward, 0 = from NOUT-1 downward |
| blank_n | input | 1 | Active-low display off |
| frame_inv | input | 1 | Frame inversion (AC) signal |
| link_a_in | input | 1 | Link A enable input value (active low) |
| link_a_out | output | 1 | Link A enable output value (active low) |
| link_a_oe | output | 1 | Link A drives when 1 |
| link_b_in | input | 1 | Link B enable input value (active low) |
| link_b_out | output | 1 | Link B enable output value (active low) |
| link_b_oe | output | 1 | Link B drives when 1 |
| drive_code | output | 2*NOUT | Level code per position: 00 Vss, 01 V43, 10 V12, 11 V0 |

## Verification
A shift-clock falling edge and a line-pulse falling edge can arrive in the same system-clock cycle, and the block must then choose between storing a word and starting a new line. The bench brings both inputs low in the same cycle. It then checks that the shown line equals the data latch from before the collision, and that the next line still needs its full word count before the outgoing enable falls and the newly loaded pattern is shown intact.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic [1:0] {
        LV_VSS = 2'b00,
        LV_V43 = 2'b01,
        LV_V12 = 2'b10,
        LV_V0  = 2'b11
    } level_t;

    typedef enum logic {
        FILL_READY,
        FILL_FULL
    } fill_state_t;

    typedef enum logic [1:0] {
        DISP_BLANK,
        DISP_NONSEL,
        DISP_SHOW
    } disp_state_t;

    function automatic level_t encode_level(input logic sel, input logic inv,
                                            input logic on, input logic show);
        level_t lv;
        if (!on)
            lv = LV_VSS;
        else if (!show || !sel)
            lv = inv ? LV_V12 : LV_V43;
        else
            lv = inv ? LV_V0 : LV_VSS;
        return lv;
    endfunction

endpackage

// File: rtl/seg_fall_detect.sv
module seg_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= sig;
    end

    assign fall = prev_q & ~sig;
endmodule

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl
    import seg_pkg::*;
#(
    parameter int NOUT = 240
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_fall,
    input  logic            line_fall,
    input  logic            en_in_n,
    input  logic            nibble_mode,
    input  logic            dir_fwd,
    input  logic [7:0]      data_in,
    output logic [NOUT-1:0] data_latch,
    output logic            full
);
    localparam int WORDS8 = NOUT / 8;
    localparam int WORDS4 = NOUT / 4;
    localparam int CW     = $clog2(WORDS4 + 1);
    localparam logic [CW-1:0] LAST8 = CW'(WORDS8 - 1);
    localparam logic [CW-1:0] LAST4 = CW'(WORDS4 - 1);

    fill_state_t     state_q, state_d;
    logic [CW-1:0]   ptr_q;
    logic            accept;
    logic            at_last;

    assign at_last = (ptr_q == (nibble_mode ? LAST4 : LAST8));
    assign accept  = (state_q == FILL_READY) && shift_fall && !en_in_n && !line_fall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FILL_READY;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_READY: if (accept && at_last) state_d = FILL_FULL;
            FILL_FULL:  if (line_fall)         state_d = FILL_READY;
            default:                           state_d = FILL_READY;
        endcase
    end

    // fill pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (line_fall)
            ptr_q <= '0;
        else if (accept && !at_last)
            ptr_q <= ptr_q + 1'b1;
    end

    assign full = (state_q == FILL_FULL);

    // per-position capture: each position knows which word and bit feed it
    for (genvar p = 0; p < NOUT; p++) begin : g_pos
        localparam int QF = p;
        localparam int QR = NOUT - 1 - p;
        localparam logic [CW-1:0] WF8 = CW'(QF / 8);
        localparam logic [CW-1:0] WF4 = CW'(QF / 4);
        localparam logic [CW-1:0] WR8 = CW'(QR / 8);
        localparam logic [CW-1:0] WR4 = CW'(QR / 4);
        localparam logic [2:0]    BF8 = 3'(QF % 8);
        localparam logic [2:0]    BF4 = 3'(QF % 4);
        localparam logic [2:0]    BR8 = 3'(QR % 8);
        localparam logic [2:0]    BR4 = 3'(QR % 4);

        logic [CW-1:0] wsel;
        logic [2:0]    bsel;
        logic          bit_q;

        always_comb begin
            unique case ({dir_fwd, nibble_mode})
                2'b11:   begin wsel = WF4; bsel = BF4; end
                2'b10:   begin wsel = WF8; bsel = BF8; end
                2'b01:   begin wsel = WR4; bsel = BR4; end
                default: begin wsel = WR8; bsel = BR8; end
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (accept && (wsel == ptr_q))
                bit_q <= data_in[bsel];
        end

        assign data_latch[p] = bit_q;
    end
endmodule

// File: rtl/seg_disp_ctrl.sv
module seg_disp_ctrl
    import seg_pkg::*;
#(
    parameter int NOUT = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_fall,
    input  logic              blank_n,
    input  logic              frame_inv,
    input  logic [NOUT-1:0]   data_latch,
    output logic [2*NOUT-1:0] drive_code
);
    disp_state_t     state_q, state_d;
    logic [NOUT-1:0] line_q;
    logic            show;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= DISP_NONSEL;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!blank_n) begin
            state_d = DISP_BLANK;
        end else begin
            unique case (state_q)
                DISP_BLANK:  state_d = DISP_NONSEL;
                DISP_NONSEL: if (line_fall) state_d = DISP_SHOW;
                DISP_SHOW:   state_d = DISP_SHOW;
                default:     state_d = DISP_NONSEL;
            endcase
        end
    end

    // line latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            line_q <= '0;
        else if (!blank_n)
            line_q <= '0;
        else if (line_fall)
            line_q <= data_latch;
    end

    assign show = (state_q == DISP_SHOW);

    // outputs
    for (genvar p = 0; p < NOUT; p++) begin : g_drv
        assign drive_code[2*p +: 2] = encode_level(line_q[p], frame_inv, blank_n, show);
    end
endmodule

// File: rtl/seg_col_loader.sv
module seg_col_loader
    import seg_pkg::*;
#(
    parameter int NOUT = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_clk,
    input  logic              line_pulse,
    input  logic [7:0]        data_in,
    input  logic              nibble_mode,
    input  logic              dir_fwd,
    input  logic              blank_n,
    input  logic              frame_inv,
    input  logic              link_a_in,
    output logic              link_a_out,
    output logic              link_a_oe,
    input  logic              link_b_in,
    output logic              link_b_out,
    output logic              link_b_oe,
    output logic [2*NOUT-1:0] drive_code
);
    logic            shift_fall;
    logic            line_fall;
    logic            en_in_n;
    logic            full;
    logic            handoff_n;
    logic [NOUT-1:0] data_latch;

    seg_fall_detect u_shift_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (shift_clk),
        .fall (shift_fall)
    );

    seg_fall_detect u_line_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (line_pulse),
        .fall (line_fall)
    );

    assign en_in_n = dir_fwd ? link_a_in : link_b_in;

    seg_fill_ctrl #(.NOUT(NOUT)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_fall (shift_fall),
        .line_fall  (line_fall),
        .en_in_n    (en_in_n),
        .nibble_mode(nibble_mode),
        .dir_fwd    (dir_fwd),
        .data_in    (data_in),
        .data_latch (data_latch),
        .full       (full)
    );

    seg_disp_ctrl #(.NOUT(NOUT)) u_disp (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_fall (line_fall),
        .blank_n   (blank_n),
        .frame_inv (frame_inv),
        .data_latch(data_latch),
        .drive_code(drive_code)
    );

    assign handoff_n  = ~full;
    assign link_a_oe  = ~dir_fwd;
    assign link_b_oe  = dir_fwd;
    assign link_a_out = dir_fwd ? 1'b1 : handoff_n;
    assign link_b_out = dir_fwd ? handoff_n : 1'b1;
endmodule

// File: rtl/seg_col_loader_chk.sv
module seg_col_loader_chk #(
    parameter int NOUT = 240
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_clk,
    input logic              line_pulse,
    input logic [7:0]        data_in,
    input logic              nibble_mode,
    input logic              dir_fwd,
    input logic              blank_n,
    input logic              frame_inv,
    input logic              link_a_in,
    input logic              link_a_out,
    input logic              link_a_oe,
    input logic              link_b_in,
    input logic              link_b_out,
    input logic              link_b_oe,
    input logic [2*NOUT-1:0] drive_code
);
    logic              sc_prev, lp_prev;
    logic              sc_fall, lp_fall;
    logic              hand_n;
    logic [2*NOUT-1:0] nonsel_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_prev <= 1'b0;
            lp_prev <= 1'b0;
        end else begin
            sc_prev <= shift_clk;
            lp_prev <= line_pulse;
        end
    end

    assign sc_fall = sc_prev & ~shift_clk;
    assign lp_fall = lp_prev & ~line_pulse;
    assign hand_n  = dir_fwd ? link_b_out : link_a_out;

    always_comb begin
        for (int i = 0; i < NOUT; i++)
            nonsel_vec[2*i +: 2] = frame_inv ? 2'b10 : 2'b01;
    end

    assert_blank_vss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> (drive_code == '0));

    assert_link_roles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dir_fwd |-> (!link_a_oe && link_b_oe && link_a_out));

    assert_link_roles_rev_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_fwd |-> (link_a_oe && !link_b_oe && link_b_out));

    assert_line_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lp_fall |=> (link_a_out && link_b_out));

    assert_handoff_after_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hand_n) && $stable(dir_fwd)) |-> $past(sc_fall));

    assert_nonsel_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blank_n) |-> (drive_code == nonsel_vec));
endmodule

bind seg_col_loader seg_col_loader_chk #(.NOUT(NOUT)) u_chk (.*);

// File: tb/sim_seg_col_loader.sv
module sim_seg_col_loader;
    localparam int N = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           shift_clk = 1'b0;
    logic           line_pulse = 1'b0;
    logic [7:0]     data_in = '0;
    logic           nibble_mode = 1'b0;
    logic           dir_fwd = 1'b1;
    logic           blank_n = 1'b1;
    logic           frame_inv = 1'b0;
    logic           link_a_in = 1'b1;
    logic           link_b_in = 1'b1;
    logic           link_a_out, link_a_oe, link_b_out, link_b_oe;
    logic [2*N-1:0] drive_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    seg_col_loader #(.NOUT(N)) u0 (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .line_pulse(line_pulse),
        .data_in(data_in), .nibble_mode(nibble_mode), .dir_fwd(dir_fwd),
        .blank_n(blank_n), .frame_inv(frame_inv),
        .link_a_in(link_a_in), .link_a_out(link_a_out), .link_a_oe(link_a_oe),
        .link_b_in(link_b_in), .link_b_out(link_b_out), .link_b_oe(link_b_oe),
        .drive_code(drive_code)
    );

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed * 53 + k * 29 + 7) ^ (k << 5));
    endfunction

    function automatic logic exp_bit(input bit fwd, input bit nib, input int seed, input int p);
        int q, w;
        logic [7:0] d;
        q = fwd ? p : N - 1 - p;
        w = nib ? 4 : 8;
        d = pat(seed, q / w);
        return d[q % w];
    endfunction

    function automatic logic [2*N-1:0] exp_drive(input bit fwd, input bit nib, input int seed,
                                                 input bit inv);
        logic [2*N-1:0] v;
        for (int p = 0; p < N; p++) begin
            if (exp_bit(fwd, nib, seed, p))
                v[2*p +: 2] = inv ? 2'b11 : 2'b00;
            else
                v[2*p +: 2] = inv ? 2'b10 : 2'b01;
        end
        return v;
    endfunction

    function automatic logic [2*N-1:0] nonsel(input bit inv);
        logic [2*N-1:0] v;
        for (int p = 0; p < N; p++) v[2*p +: 2] = inv ? 2'b10 : 2'b01;
        return v;
    endfunction

    function automatic logic hand();
        return dir_fwd ? link_b_out : link_a_out;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic shift_word(input logic [7:0] d);
        @(negedge clk);
        data_in   = d;
        shift_clk = 1'b1;
        repeat (2) @(negedge clk);
        shift_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_line();
        @(negedge clk);
        line_pulse = 1'b1;
        repeat (2) @(negedge clk);
        line_pulse = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic load_line(input int seed);
        int nw;
        nw = nibble_mode ? N / 4 : N / 8;
        for (int k = 0; k < nw; k++) begin
            if (k == nw - 1)
                chk(hand() == 1'b1, "R4 enable high before last word", 64'(hand()), 64'd1);
            shift_word(pat(seed, k));
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11 reset state
        chk(drive_code == nonsel(1'b0), "R11 reset codes", 64'(drive_code), 64'(nonsel(1'b0)));
        chk(link_a_out && link_b_out, "R11 reset links", {62'd0, link_a_out, link_b_out}, 64'd3);
        // R9 link roles in both directions
        chk(!link_a_oe && link_b_oe, "R9 forward roles", {62'd0, link_a_oe, link_b_oe}, 64'd1);
        dir_fwd = 1'b0;
        @(negedge clk);
        chk(link_a_oe && !link_b_oe, "R9 reverse roles", {62'd0, link_a_oe, link_b_oe}, 64'd2);

        // sweep both directions and both widths; R2 upper nibble carries junk in 4-bit mode
        link_a_in = 1'b0;
        link_b_in = 1'b0;
        for (int d = 1; d >= 0; d--) begin
            for (int m = 0; m < 2; m++) begin
                for (int s = 0; s < 2; s++) begin
                    dir_fwd     = 1'(d);
                    nibble_mode = 1'(m);
                    frame_inv   = 1'b1;
                    load_line(s + 2 * m + 4 * d);
                    chk(hand() == 1'b0, "R4 enable low when full", 64'(hand()), 64'd0);
                    chk((dir_fwd ? link_a_out : link_b_out) == 1'b1, "R9 idle link stays high",
                        64'(dir_fwd ? link_a_out : link_b_out), 64'd1);
                    shift_word(8'hFF); // R4 ignored once full
                    pulse_line();
                    chk(hand() == 1'b1, "R5 enable released", 64'(hand()), 64'd1);
                    chk(drive_code == exp_drive(1'(d), 1'(m), s + 2 * m + 4 * d, 1'b1),
                        m ? "R2 R3 nibble fill order" : "R3 byte fill order",
                        64'(drive_code), 64'(exp_drive(1'(d), 1'(m), s + 2 * m + 4 * d, 1'b1)));
                    frame_inv = 1'b0;
                    @(negedge clk);
                    chk(drive_code == exp_drive(1'(d), 1'(m), s + 2 * m + 4 * d, 1'b0),
                        "R6 codes with inversion low",
                        64'(drive_code), 64'(exp_drive(1'(d), 1'(m), s + 2 * m + 4 * d, 1'b0)));
                end
            end
        end
        // last line shown: dir 0, nibble 1, seed 3

        // R1 enable high: words ignored, next line repeats previous latch
        link_a_in = 1'b1;
        link_b_in = 1'b1;
        for (int k = 0; k < N / 4; k++) shift_word(8'hA5);
        chk(hand() == 1'b1, "R1 no handoff while disabled", 64'(hand()), 64'd1);
        pulse_line();
        chk(drive_code == exp_drive(1'b0, 1'b1, 3, 1'b0), "R1 disabled words ignored",
            64'(drive_code), 64'(exp_drive(1'b0, 1'b1, 3, 1'b0)));

        // R7 / R8 blanking
        link_a_in   = 1'b0;
        link_b_in   = 1'b0;
        dir_fwd     = 1'b1;
        nibble_mode = 1'b0;
        frame_inv   = 1'b1;
        load_line(5);
        pulse_line();
        chk(drive_code == exp_drive(1'b1, 1'b0, 5, 1'b1), "R3 line before blank",
            64'(drive_code), 64'(exp_drive(1'b1, 1'b0, 5, 1'b1)));
        blank_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(drive_code == '0, "R7 blank forces Vss", 64'(drive_code), 64'd0);
        pulse_line();
        load_line(6);
        chk(drive_code == '0, "R7 still Vss while loading", 64'(drive_code), 64'd0);
        blank_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(drive_code == nonsel(1'b1), "R8 non-select after release",
            64'(drive_code), 64'(nonsel(1'b1)));
        repeat (6) @(negedge clk);
        chk(drive_code == nonsel(1'b1), "R8 non-select holds until line edge",
            64'(drive_code), 64'(nonsel(1'b1)));
        pulse_line();
        chk(drive_code == exp_drive(1'b1, 1'b0, 6, 1'b1), "R7 data loaded during blank",
            64'(drive_code), 64'(exp_drive(1'b1, 1'b0, 6, 1'b1)));

        // R10 coincident shift and line edges
        @(negedge clk);
        data_in    = 8'h3C;
        shift_clk  = 1'b1;
        line_pulse = 1'b1;
        repeat (2) @(negedge clk);
        shift_clk  = 1'b0;
        line_pulse = 1'b0;
        repeat (2) @(negedge clk);
        chk(drive_code == exp_drive(1'b1, 1'b0, 6, 1'b1), "R10 transfer wins collision",
            64'(drive_code), 64'(exp_drive(1'b1, 1'b0, 6, 1'b1)));
        load_line(7);
        chk(hand() == 1'b0, "R10 full after whole count", 64'(hand()), 64'd0);
        pulse_line();
        chk(drive_code == exp_drive(1'b1, 1'b0, 7, 1'b1), "R10 colliding word dropped",
            64'(drive_code), 64'(exp_drive(1'b1, 1'b0, 7, 1'b1)));

        done = 1'b1;
        finish_run();
    end
endmodule